// File: doc/BRIEF.md
# Castout Bus-Request Slot Arbiter

Several cache devices share one wired request line. A device drives that line when it has a line waiting in its castout buffer, or when a snoop hit a dirty line that must be written back. This block is the per-device controller for that line. It decides when the device may start driving the request, when it must stop, and when it must float the output. It also tells the castout buffer when a transfer may begin and when the line has been fully written.

Every device runs an identical free-running slot counter. The counter is cleared by the common synchronous reset, so all copies agree on its value. A device starts a castout request only if two things hold in the same cycle: the shared line is free, and the counter equals the device's configuration ID. Because of this rule, two devices cannot begin requesting in the same cycle.

A snoop that hits dirty data is handled differently. The device raises the request and pulses address retry straight away, without waiting for its slot. If a device is requesting a castout and sees address retry from another device, it goes through a short backoff window. During that window it drives the line negated, or it floats the line if the fellow-device indicator was active when the retry arrived. After the window it waits for the line and its slot again, just as before.

Top module: `castout_arb`

## Requirements
- R1: In the cycle after a clock edge that sees `sync_rst` high, all five outputs are 0, the controller is idle and the slot counter is 0.
- R2: The slot counter holds 0 in the first cycle after reset. It then increases by one on every clock and wraps modulo 2^SLOT_W (0,1,2,3,0… with the default SLOT_W = 2).
- R3: While `castout_pend` is high and `breq_in` is high, the device does not start driving the request. The first edge that sees `castout_pend` only moves the controller from idle into waiting, with no drive.
- R4: After that first edge, a castout request starts on the first edge that sees `breq_in` low with the slot counter equal to `cfg_id`. From the next cycle on, `req_oe` = 1 and `req_val` = 1.
- R5: An edge that sees `snoop_dirty` while the controller is idle, waiting or in backoff starts a snoop request at once, whatever the slot. In the next cycle `req_oe`, `req_val` and `retry_drv` are 1. `retry_drv` stays high for exactly one cycle.
- R6: While a castout request is driven, an edge that sees `aretry_in` high with `fdn_in` low starts a backoff of BACKOFF_CYC cycles (default 2). During those cycles `req_oe` = 1 and `req_val` = 0.
- R7: If `fdn_in` is high on that same edge, `req_oe` = 0 for the whole backoff window.
- R8: When the backoff window ends, the controller never goes to the transfer state. It waits again: the request starts only under the R4 rule, and nothing is driven while `breq_in` stays high.
- R9: An edge that sees `bus_grant` while a request is driven makes `co_go` high for exactly one cycle. The request stays driven (`req_oe` = `req_val` = 1) until `xfer_done`. If `aretry_in` hits a castout request on the same edge as `bus_grant`, the retry wins: the controller backs off and `co_go` stays 0.
- R10: An edge that sees `xfer_done` releases the line (`req_oe` = 0 in the next cycle). It also makes `pend_clr` high for exactly one cycle, but only when the finished request was a castout. A snoop write-back gives no `pend_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sync_rst | input | 1 | Global synchronous reset and counter sync, active high |
| cfg_id | input | SLOT_W | This device's slot number |
| castout_pend | input | 1 | Castout buffer holds a line to copy back |
| snoop_dirty | input | 1 | Snoop hit a dirty line in this device (one-cycle pulse) |
| breq_in | input | 1 | Sampled level of the shared request line, 1 = asserted |
| aretry_in | input | 1 | Sampled address retry line, 1 = asserted |
| fdn_in | input | 1 | Fellow-device indicator, sampled with address retry |
| bus_grant | input | 1 | Bus granted for this device's pending request |
| xfer_done | input | 1 | Current castout or write-back transfer finished |
| req_oe | output | 1 | Drive enable for the shared request line (0 = high impedance) |
| req_val | output | 1 | Value driven on the request line, 1 = asserted |
| retry_drv | output | 1 | Drive address retry for a snoop write-back |
| co_go | output | 1 | One-cycle permission for the transfer to start |
| pend_clr | output | 1 | One-cycle pulse that clears the castout-pending flag |

## Verification
The key collision is a bus grant and another device's address retry arriving on the same edge while a castout request is driven. The bench creates it on purpose: once a request has risen, it raises both `bus_grant` and `aretry_in` in one cycle. It then checks that the next cycle shows a negated drive with no `co_go`, and that a new request later follows the slot rule. A second overlap is also provoked: random backoffs are placed in the middle of random castout flows, so a retry can meet the wait for a busy line. In those cases every request rise is judged against the bench's own copy of the counter and of the line level at the previous edge.

// File: rtl/castout_arb_pkg.sv
package castout_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_FREE = 3'd1,
    ST_WAIT_SLOT = 3'd2,
    ST_REQUEST   = 3'd3,
    ST_BACKOFF   = 3'd4,
    ST_TRANSFER  = 3'd5
  } arb_state_e;

  typedef enum logic {
    SRC_CASTOUT = 1'b0,
    SRC_SNOOP   = 1'b1
  } req_src_e;

  // A new castout request may begin: line free and our slot is up.
  function automatic logic slot_open(logic line_busy, int unsigned cnt,
                                     int unsigned id);
    return !line_busy && (cnt == id);
  endfunction

  // Next slot value, modulo the number of slots.
  function automatic int unsigned slot_step(int unsigned cnt,
                                            int unsigned n_slots);
    return (cnt + 1) % n_slots;
  endfunction

  // Value loaded into the backoff down-counter.
  function automatic int unsigned backoff_load(int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              sync_rst,
  output logic [SLOT_W-1:0] cnt
);
  import castout_arb_pkg::*;

  localparam int unsigned N_SLOTS = 1 << SLOT_W;

  logic [SLOT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = SLOT_W'(slot_step(int'(cnt), N_SLOTS));
  end

  always_ff @(posedge clk) begin
    if (sync_rst) cnt <= '0;
    else          cnt <= cnt_nxt;
  end
endmodule

// File: rtl/slot_gate.sv
module slot_gate #(
  parameter int SLOT_W = 2
) (
  input  logic [SLOT_W-1:0] cnt,
  input  logic [SLOT_W-1:0] cfg_id,
  input  logic              breq_in,
  output logic              may_assert
);
  import castout_arb_pkg::*;

  always_comb begin
    may_assert = slot_open(breq_in, int'(cnt), int'(cfg_id));
  end
endmodule

// File: rtl/req_fsm.sv
module req_fsm #(
  parameter int BACKOFF_CYC = 2
) (
  input  logic                        clk,
  input  logic                        sync_rst,
  input  logic                        castout_pend,
  input  logic                        snoop_dirty,
  input  logic                        breq_in,
  input  logic                        aretry_in,
  input  logic                        fdn_in,
  input  logic                        bus_grant,
  input  logic                        xfer_done,
  input  logic                        may_assert,
  output castout_arb_pkg::arb_state_e state,
  output castout_arb_pkg::req_src_e   src,
  output logic                        fdn_seen,
  output logic                        ev_snoop_take,
  output logic                        ev_backoff,
  output logic                        ev_grant,
  output logic                        ev_done
);
  import castout_arb_pkg::*;

  localparam int BO_W = (BACKOFF_CYC > 2) ? $clog2(BACKOFF_CYC) : 1;
  localparam logic [BO_W-1:0] BO_INIT = BO_W'(backoff_load(BACKOFF_CYC));

  arb_state_e      nxt;
  req_src_e        src_nxt;
  logic [BO_W-1:0] bo_cnt;
  logic            can_snoop;
  logic            co_retry;
  logic            ev_slot;

  always_comb begin
    can_snoop = (state == ST_IDLE) || (state == ST_WAIT_FREE) ||
                (state == ST_WAIT_SLOT) || (state == ST_BACKOFF);
    co_retry  = (state == ST_REQUEST) && (src == SRC_CASTOUT) && aretry_in;
  end

  always_comb begin
    nxt           = state;
    src_nxt       = src;
    ev_snoop_take = 1'b0;
    ev_backoff    = 1'b0;
    ev_grant      = 1'b0;
    ev_done       = 1'b0;
    ev_slot       = 1'b0;
    if (can_snoop && snoop_dirty) begin
      nxt           = ST_REQUEST;
      src_nxt       = SRC_SNOOP;
      ev_snoop_take = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (castout_pend) nxt = breq_in ? ST_WAIT_FREE : ST_WAIT_SLOT;
        end
        ST_WAIT_FREE, ST_WAIT_SLOT: begin
          if (!castout_pend) begin
            nxt = ST_IDLE;
          end else if (may_assert) begin
            nxt     = ST_REQUEST;
            src_nxt = SRC_CASTOUT;
            ev_slot = 1'b1;
          end else begin
            nxt = breq_in ? ST_WAIT_FREE : ST_WAIT_SLOT;
          end
        end
        ST_REQUEST: begin
          if (co_retry) begin
            nxt        = ST_BACKOFF;
            ev_backoff = 1'b1;
          end else if (bus_grant) begin
            nxt      = ST_TRANSFER;
            ev_grant = 1'b1;
          end
        end
        ST_BACKOFF: begin
          if (bo_cnt == '0) nxt = castout_pend ? ST_WAIT_FREE : ST_IDLE;
        end
        ST_TRANSFER: begin
          if (xfer_done) begin
            nxt     = ST_IDLE;
            ev_done = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      state    <= ST_IDLE;
      src      <= SRC_CASTOUT;
      fdn_seen <= 1'b0;
      bo_cnt   <= '0;
    end else begin
      state <= nxt;
      src   <= src_nxt;
      if (ev_backoff) begin
        fdn_seen <= fdn_in;
        bo_cnt   <= BO_INIT;
      end else if (state == ST_BACKOFF && bo_cnt != '0) begin
        bo_cnt <= bo_cnt - 1'b1;
      end
      if (ev_slot) fdn_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/line_drive.sv
module line_drive (
  input  logic                        clk,
  input  logic                        sync_rst,
  input  castout_arb_pkg::arb_state_e state,
  input  castout_arb_pkg::req_src_e   src,
  input  logic                        fdn_seen,
  input  logic                        ev_snoop_take,
  input  logic                        ev_grant,
  input  logic                        ev_done,
  output logic                        req_oe,
  output logic                        req_val,
  output logic                        retry_drv,
  output logic                        co_go,
  output logic                        pend_clr
);
  import castout_arb_pkg::*;

  logic holding;

  always_comb begin
    holding = (state == ST_REQUEST) || (state == ST_TRANSFER);
    req_val = holding;
    req_oe  = holding || ((state == ST_BACKOFF) && !fdn_seen);
  end

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      retry_drv <= 1'b0;
      co_go     <= 1'b0;
      pend_clr  <= 1'b0;
    end else begin
      retry_drv <= ev_snoop_take;
      co_go     <= ev_grant;
      pend_clr  <= ev_done && (src == SRC_CASTOUT);
    end
  end
endmodule

// File: rtl/castout_arb.sv
module castout_arb #(
  parameter int SLOT_W      = 2,
  parameter int BACKOFF_CYC = 2
) (
  input  logic              clk,
  input  logic              sync_rst,
  input  logic [SLOT_W-1:0] cfg_id,
  input  logic              castout_pend,
  input  logic              snoop_dirty,
  input  logic              breq_in,
  input  logic              aretry_in,
  input  logic              fdn_in,
  input  logic              bus_grant,
  input  logic              xfer_done,
  output logic              req_oe,
  output logic              req_val,
  output logic              retry_drv,
  output logic              co_go,
  output logic              pend_clr
);
  import castout_arb_pkg::*;

  logic [SLOT_W-1:0] slot_cnt;
  logic              may_assert;
  arb_state_e        fsm_state;
  req_src_e          req_src;
  logic              fdn_seen;
  logic              ev_snoop_take;
  logic              ev_backoff;
  logic              ev_grant;
  logic              ev_done;

  slot_counter #(.SLOT_W(SLOT_W)) u_cnt (
    .clk      (clk),
    .sync_rst (sync_rst),
    .cnt      (slot_cnt)
  );

  slot_gate #(.SLOT_W(SLOT_W)) u_gate (
    .cnt        (slot_cnt),
    .cfg_id     (cfg_id),
    .breq_in    (breq_in),
    .may_assert (may_assert)
  );

  req_fsm #(.BACKOFF_CYC(BACKOFF_CYC)) u_fsm (
    .clk           (clk),
    .sync_rst      (sync_rst),
    .castout_pend  (castout_pend),
    .snoop_dirty   (snoop_dirty),
    .breq_in       (breq_in),
    .aretry_in     (aretry_in),
    .fdn_in        (fdn_in),
    .bus_grant     (bus_grant),
    .xfer_done     (xfer_done),
    .may_assert    (may_assert),
    .state         (fsm_state),
    .src           (req_src),
    .fdn_seen      (fdn_seen),
    .ev_snoop_take (ev_snoop_take),
    .ev_backoff    (ev_backoff),
    .ev_grant      (ev_grant),
    .ev_done       (ev_done)
  );

  line_drive u_drv (
    .clk           (clk),
    .sync_rst      (sync_rst),
    .state         (fsm_state),
    .src           (req_src),
    .fdn_seen      (fdn_seen),
    .ev_snoop_take (ev_snoop_take),
    .ev_grant      (ev_grant),
    .ev_done       (ev_done),
    .req_oe        (req_oe),
    .req_val       (req_val),
    .retry_drv     (retry_drv),
    .co_go         (co_go),
    .pend_clr      (pend_clr)
  );
endmodule

// File: rtl/castout_arb_chk.sv
module castout_arb_chk #(
  parameter int SLOT_W = 2
) (
  input logic                        clk,
  input logic                        sync_rst,
  input logic [SLOT_W-1:0]           cfg_id,
  input logic                        castout_pend,
  input logic                        snoop_dirty,
  input logic                        breq_in,
  input logic                        aretry_in,
  input logic                        fdn_in,
  input logic                        bus_grant,
  input logic                        xfer_done,
  input logic                        req_oe,
  input logic                        req_val,
  input logic                        retry_drv,
  input logic                        co_go,
  input logic                        pend_clr,
  input logic [SLOT_W-1:0]           slot_cnt,
  input castout_arb_pkg::arb_state_e fsm_state,
  input castout_arb_pkg::req_src_e   req_src,
  input logic                        ev_backoff
);
  import castout_arb_pkg::*;

  logic rst_seen = 1'b0;
  logic snoop_ok;
  logic co_req;

  always_comb begin
    snoop_ok = (fsm_state == ST_IDLE) || (fsm_state == ST_WAIT_FREE) ||
               (fsm_state == ST_WAIT_SLOT) || (fsm_state == ST_BACKOFF);
    co_req   = (fsm_state == ST_REQUEST) && (req_src == SRC_CASTOUT);
  end

  always @(posedge clk) begin
    if (rst_seen) begin
      assert_reset_quiet_R1: assert (!req_oe && !req_val && !retry_drv &&
                                     !co_go && !pend_clr && slot_cnt == '0);
    end
    rst_seen <= sync_rst;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (sync_rst)
    !$past(sync_rst) |-> slot_cnt == SLOT_W'($past(slot_cnt) + 1'b1));

  assert_busy_no_start_R3: assert property (@(posedge clk) disable iff (sync_rst)
    ((fsm_state == ST_WAIT_FREE || fsm_state == ST_WAIT_SLOT) && breq_in &&
     !snoop_dirty) |=> !req_val);

  assert_start_in_slot_R4: assert property (@(posedge clk) disable iff (sync_rst)
    ($rose(req_val) && !retry_drv) |->
      ($past(slot_cnt) == $past(cfg_id)) && !$past(breq_in));

  assert_snoop_start_R5: assert property (@(posedge clk) disable iff (sync_rst)
    (snoop_ok && snoop_dirty) |=> (retry_drv && req_val && req_oe));

  assert_retry_pulse_R5: assert property (@(posedge clk) disable iff (sync_rst)
    retry_drv |=> !retry_drv);

  assert_backoff_negate_R6: assert property (@(posedge clk) disable iff (sync_rst)
    (co_req && aretry_in && !fdn_in) |=> (req_oe && !req_val && !co_go));

  assert_backoff_float_R7: assert property (@(posedge clk) disable iff (sync_rst)
    (co_req && aretry_in && fdn_in) |=> !req_oe);

  assert_no_misread_R8: assert property (@(posedge clk) disable iff (sync_rst)
    (fsm_state == ST_BACKOFF) |=> (fsm_state != ST_TRANSFER));

  assert_go_pulse_R9: assert property (@(posedge clk) disable iff (sync_rst)
    co_go |=> !co_go);

  assert_go_holds_R9: assert property (@(posedge clk) disable iff (sync_rst)
    co_go |-> (req_oe && req_val));

  assert_release_R10: assert property (@(posedge clk) disable iff (sync_rst)
    pend_clr |-> (!req_oe && !$past(pend_clr)));

  assert_backoff_event_R6: assert property (@(posedge clk) disable iff (sync_rst)
    ev_backoff |-> (aretry_in && !xfer_done && castout_pend | !castout_pend));

endmodule

bind castout_arb castout_arb_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk          (clk),
  .sync_rst     (sync_rst),
  .cfg_id       (cfg_id),
  .castout_pend (castout_pend),
  .snoop_dirty  (snoop_dirty),
  .breq_in      (breq_in),
  .aretry_in    (aretry_in),
  .fdn_in       (fdn_in),
  .bus_grant    (bus_grant),
  .xfer_done    (xfer_done),
  .req_oe       (req_oe),
  .req_val      (req_val),
  .retry_drv    (retry_drv),
  .co_go        (co_go),
  .pend_clr     (pend_clr),
  .slot_cnt     (slot_cnt),
  .fsm_state    (fsm_state),
  .req_src      (req_src),
  .ev_backoff   (ev_backoff)
);

// File: tb/tb_castout_arb.sv
`timescale 1ns/1ps
module tb_castout_arb;
  localparam int SLOT_W = 2;

  logic              clk = 1'b0;
  logic              sync_rst = 1'b1;
  logic [SLOT_W-1:0] cfg_id = '0;
  logic              castout_pend = 1'b0;
  logic              snoop_dirty = 1'b0;
  logic              breq_in = 1'b0;
  logic              aretry_in = 1'b0;
  logic              fdn_in = 1'b0;
  logic              bus_grant = 1'b0;
  logic              xfer_done = 1'b0;
  logic              req_oe, req_val, retry_drv, co_go, pend_clr;

  int checks = 0;
  int errors = 0;
  logic [SLOT_W-1:0] cnt_m = '0;   // bench copy of the slot counter
  bit finished = 0;

  castout_arb #(.SLOT_W(SLOT_W), .BACKOFF_CYC(2)) dut (
    .clk(clk), .sync_rst(sync_rst), .cfg_id(cfg_id),
    .castout_pend(castout_pend), .snoop_dirty(snoop_dirty),
    .breq_in(breq_in), .aretry_in(aretry_in), .fdn_in(fdn_in),
    .bus_grant(bus_grant), .xfer_done(xfer_done),
    .req_oe(req_oe), .req_val(req_val), .retry_drv(retry_drv),
    .co_go(co_go), .pend_clr(pend_clr)
  );

  always #2.5 clk = ~clk;

  // {req_oe, req_val, retry_drv, co_go, pend_clr}
  function automatic logic [4:0] outs();
    return {req_oe, req_val, retry_drv, co_go, pend_clr};
  endfunction

  function automatic logic expect_start(logic busy, logic [SLOT_W-1:0] c,
                                        logic [SLOT_W-1:0] id);
    return (busy == 1'b0) && (c == id);
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic rst_at;
    rst_at = sync_rst;
    @(posedge clk);
    cnt_m = rst_at ? '0 : SLOT_W'(cnt_m + 1'b1);
    #1;
  endtask

  // First edge with castout pending: idle -> waiting, no drive (R3)
  task automatic arm(int busy);
    castout_pend = 1'b1;
    breq_in = (busy > 0);
    tick();
    chk("R3 arm", outs(), 5'b00000);
  endtask

  // Wait for the request to rise; it must rise exactly on the slot rule (R4)
  task automatic wait_rise(int busy, string tag);
    bit done;
    done = 0;
    breq_in = (busy > 0);
    for (int i = 0; i < 60 && !done; i++) begin
      logic exp_rise;
      exp_rise = expect_start(breq_in, cnt_m, cfg_id);
      tick();
      if (exp_rise) begin
        chk({"R4 slot start ", tag}, outs(), 5'b11000);
        done = 1;
      end else if (outs() !== 5'b00000) begin
        chk({"R3 no early drive ", tag}, outs(), 5'b00000);
        done = 1;
      end
      if (busy > 0) busy--;
      breq_in = (busy > 0);
    end
    if (!done) chk({"R4 never started ", tag}, outs(), 5'b11000);
  endtask

  task automatic finish_xfer(int len, logic castout);
    bus_grant = 1'b1;
    tick();
    bus_grant = 1'b0;
    chk("R9 go pulse", outs(), 5'b11010);
    for (int i = 0; i < len; i++) begin
      tick();
      chk("R9 hold during transfer", outs(), 5'b11000);
    end
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R10 release", outs(), castout ? 5'b00001 : 5'b00000);
    if (castout) castout_pend = 1'b0;
    tick();
    chk("R10 single pend_clr", outs(), 5'b00000);
  endtask

  // Other device's retry while our castout request is up (R6/R7/R8)
  task automatic backoff(logic fdn, int hold);
    logic [4:0] e;
    e = fdn ? 5'b00000 : 5'b10000;
    aretry_in = 1'b1;
    fdn_in = fdn;
    breq_in = 1'b1;
    tick();
    aretry_in = 1'b0;
    fdn_in = 1'b0;
    chk(fdn ? "R7 float cycle 1" : "R6 negate cycle 1", outs(), e);
    tick();
    chk(fdn ? "R7 float cycle 2" : "R6 negate cycle 2", outs(), e);
    wait_rise(hold, "R8 after backoff");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0b_a5e7));
    // R1: reset state
    repeat (3) tick();
    chk("R1 reset outputs", outs(), 5'b00000);
    sync_rst = 1'b0;
    tick();
    chk("R1 idle after reset", outs(), 5'b00000);

    // R2/R4: first start after reset shows counter began at 0
    cfg_id = 2'd2;
    arm(0);
    wait_rise(0, "R2 counter from reset");
    finish_xfer(1, 1'b1);

    // R3: line busy for a long time
    cfg_id = 2'd1;
    arm(7);
    wait_rise(7, "R3 busy line");
    finish_xfer(0, 1'b1);

    // R5: snoop dirty hit starts at once, retry one cycle
    cfg_id = SLOT_W'(cnt_m + 2'd2);
    snoop_dirty = 1'b1;
    tick();
    snoop_dirty = 1'b0;
    chk("R5 snoop start", outs(), 5'b11100);
    tick();
    chk("R5 retry single cycle", outs(), 5'b11000);
    finish_xfer(2, 1'b0);

    // R6 then R8
    cfg_id = 2'd3;
    arm(0);
    wait_rise(0, "R6 setup");
    backoff(1'b0, 4);
    finish_xfer(0, 1'b1);

    // R7 then R8
    cfg_id = 2'd0;
    arm(2);
    wait_rise(2, "R7 setup");
    backoff(1'b1, 3);
    finish_xfer(1, 1'b1);

    // R9: grant and retry on the same edge, retry wins
    cfg_id = 2'd1;
    arm(0);
    wait_rise(0, "R9 collision setup");
    bus_grant = 1'b1;
    aretry_in = 1'b1;
    breq_in = 1'b1;
    tick();
    bus_grant = 1'b0;
    aretry_in = 1'b0;
    chk("R9 retry beats grant", outs(), 5'b10000);
    tick();
    chk("R9 still backing off", outs(), 5'b10000);
    wait_rise(2, "R9 after collision");
    finish_xfer(0, 1'b1);

    // R5: snoop during a busy-line wait overrides the wait
    cfg_id = SLOT_W'(cnt_m + 2'd3);
    arm(5);
    breq_in = 1'b1;
    snoop_dirty = 1'b1;
    tick();
    snoop_dirty = 1'b0;
    chk("R5 snoop while waiting", outs(), 5'b11100);
    finish_xfer(0, 1'b0);
    castout_pend = 1'b0;
    breq_in = 1'b0;
    tick();

    // Random castout flows with occasional backoff
    for (int it = 0; it < 40; it++) begin
      int gap;
      cfg_id = SLOT_W'($urandom % 4);
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) tick();
      arm(0);
      wait_rise(int'($urandom % 6), "R4 random");
      if (($urandom % 3) == 0)
        backoff(logic'($urandom % 2), 1 + int'($urandom % 4));
      finish_xfer(int'($urandom % 3), 1'b1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule